// File: doc/BRIEF.md
# I2C Register Target with Indexed and Sequential Access

This block is an I2C target that holds a small bank of 8-bit control registers. Each register drives a parallel output byte. Typical contents are output enables and the skew, edge-rate and amplitude settings of the analog circuits around it. A controller on the two-wire bus can write or read one register chosen by index. It can also write or read a run of registers, starting at an index and moving upward one register per byte.

SCL and SDA come in as plain inputs. They are synchronised to the system clock, and start and stop conditions are recognised from them. SDA is driven through a single pull-low enable, so the pad stays open-drain. After the address, the first byte a controller writes is a command byte that selects the starting register. A read is done in three steps: a write of the command byte, a repeated start, then the read address. The target does not stretch the clock.

Top module: `i2c_regbank_target`

## Requirements
- R1: Only the 7-bit address 0x6B is acknowledged: 0xD6 for a write and 0xD7 for a read. For any other address the target does not pull SDA low at the acknowledge slot, and it keeps SDA released until the next start or stop.
- R2: At reset, register i (default bank of 8) holds (0xA5 + 0x11*i) mod 256: A5, B6, C7, D8, E9, FA, 0B, 1C.
- R3: Byte write: after an acknowledged 0xD6, the first byte is taken as the register index and the next byte, sent MSB first, is stored in that register. The target acknowledges each byte by pulling SDA low in the ninth clock.
- R4: Block write: each further data byte is stored at the next higher index. A stop after any complete byte keeps every byte already acknowledged and leaves the rest of the bank unchanged.
- R5: Byte read: a command byte is written, then a repeated start and 0xD7 follow. The target then sends the indexed register MSB first, and a NACK from the controller ends the read.
- R6: Block read: after each byte the controller ACKs, the target sends the register at the next higher index. After a NACK it keeps SDA released until the next start or stop.
- R7: An index at or above the bank size reads as 0x00. A write to such an index is acknowledged but changes no register output.
- R8: The target changes its SDA pull only while SCL is low, and it is not pulling SDA once a stop has been seen.
- R9: Byte i of the parallel output always equals register i. A write appears there before the stop that ends the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; loads the register defaults |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | When high, the pad pulls SDA low; when low, SDA is released |
| regs_o | output | NUM_REGS*8 | Register bank, register i on bits [8i+7:8i] |

## Verification
The bench runs the bus protocol against a behavioural model of the register bank and compares the two on every clock while the bus is idle.

Data values such as 0x5C and 0x01 against 0x80 are asymmetric, so they expose a reversed bit order. A lone byte write shows whether the index is taken from the command byte. Block writes that are stopped part-way show whether the index advances and whether a stop is treated as a clean end.

Block writes and reads that run past the top of the bank separate the implemented registers from the ones that read as zero and ignore writes. Foreign addresses, for both read and write, show whether the target stays off the bus. A monitor checks that SDA is never touched while SCL is high.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_CMD,
        ST_CACK,
        ST_WR,
        ST_TX,
        ST_TACK,
        ST_IGNORE
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] ptr;
        logic [BYTE_W-1:0] txbyte;
        logic              rw;
        logic              nack;
        logic              pull;
        logic              wr_en;
        logic [BYTE_W-1:0] wr_idx;
        logic [BYTE_W-1:0] wr_data;
    } fsm_regs_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES-1:0] scl_sync_d, scl_sync_q;
    logic [STAGES-1:0] sda_sync_d, sda_sync_q;
    logic              scl_prev_d, scl_prev_q;
    logic              sda_prev_d, sda_prev_q;
    logic              scl_s, sda_s;

    assign scl_s = scl_sync_q[STAGES-1];
    assign sda_s = sda_sync_q[STAGES-1];

    always_comb begin
        scl_sync_d = {scl_sync_q[STAGES-2:0], scl_i};
        sda_sync_d = {sda_sync_q[STAGES-2:0], sda_i};
        scl_prev_d = scl_s;
        sda_prev_d = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync_q <= '1;
            sda_sync_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sync_q <= scl_sync_d;
            sda_sync_q <= sda_sync_d;
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    // Edges and bus conditions, all taken from the synchronised lines.
    assign sda_o      = sda_s;
    assign scl_rise_o = scl_s & ~scl_prev_q;
    assign scl_fall_o = ~scl_s & scl_prev_q;
    assign start_o    = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_o     = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h6B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [BYTE_W-1:0] rd_idx_o,
    output logic              sda_pull_o,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] wr_idx_o,
    output logic [BYTE_W-1:0] wr_data_o
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    fsm_regs_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        if (stop_i) begin
            st_d.state = ST_IDLE;
            st_d.pull  = 1'b0;
        end else if (start_i) begin
            st_d.state = ST_ADDR;
            st_d.cnt   = '0;
            st_d.pull  = 1'b0;
        end else begin
            unique case (st_q.state)
                ST_ADDR, ST_CMD, ST_WR: begin
                    if (scl_rise_i && st_q.cnt < FULL) begin
                        st_d.shreg = {st_q.shreg[BYTE_W-2:0], sda_s_i};
                        st_d.cnt   = st_q.cnt + 1'b1;
                    end else if (scl_fall_i && st_q.cnt == FULL) begin
                        st_d.cnt = '0;
                        if (st_q.state == ST_ADDR) begin
                            if (st_q.shreg[7:1] == DEV_ADDR) begin
                                st_d.pull  = 1'b1;
                                st_d.rw    = st_q.shreg[0];
                                st_d.state = ST_AACK;
                            end else begin
                                st_d.state = ST_IGNORE;
                            end
                        end else if (st_q.state == ST_CMD) begin
                            st_d.ptr   = st_q.shreg;
                            st_d.pull  = 1'b1;
                            st_d.state = ST_CACK;
                        end else begin
                            st_d.wr_en   = 1'b1;
                            st_d.wr_idx  = st_q.ptr;
                            st_d.wr_data = st_q.shreg;
                            st_d.ptr     = st_q.ptr + 1'b1;
                            st_d.pull    = 1'b1;
                            st_d.state   = ST_CACK;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall_i) begin
                        if (st_q.rw) begin
                            st_d.txbyte = {rd_data_i[BYTE_W-2:0], 1'b0};
                            st_d.pull   = ~rd_data_i[BYTE_W-1];
                            st_d.cnt    = CNT_W'(1);
                            st_d.state  = ST_TX;
                        end else begin
                            st_d.pull  = 1'b0;
                            st_d.state = ST_CMD;
                        end
                    end
                end
                ST_CACK: begin
                    if (scl_fall_i) begin
                        st_d.pull  = 1'b0;
                        st_d.state = ST_WR;
                    end
                end
                ST_TX: begin
                    if (scl_fall_i) begin
                        if (st_q.cnt < FULL) begin
                            st_d.pull   = ~st_q.txbyte[BYTE_W-1];
                            st_d.txbyte = {st_q.txbyte[BYTE_W-2:0], 1'b0};
                            st_d.cnt    = st_q.cnt + 1'b1;
                        end else begin
                            st_d.pull  = 1'b0;
                            st_d.ptr   = st_q.ptr + 1'b1;
                            st_d.state = ST_TACK;
                        end
                    end
                end
                ST_TACK: begin
                    if (scl_rise_i) begin
                        st_d.nack = sda_s_i;
                    end else if (scl_fall_i) begin
                        if (!st_q.nack) begin
                            st_d.txbyte = {rd_data_i[BYTE_W-2:0], 1'b0};
                            st_d.pull   = ~rd_data_i[BYTE_W-1];
                            st_d.cnt    = CNT_W'(1);
                            st_d.state  = ST_TX;
                        end else begin
                            st_d.state = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_idx_o   = st_q.ptr;
    assign sda_pull_o = st_q.pull;
    assign wr_en_o    = st_q.wr_en;
    assign wr_idx_o   = st_q.wr_idx;
    assign wr_data_o  = st_q.wr_data;

    // R8: the pull moves only after a falling SCL edge or a bus condition
    a_r8_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.pull) |-> $past(scl_fall_i || start_i || stop_i));

    // R8: a stop leaves SDA released
    a_r8_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !st_q.pull);

    // R3: a register write is launched only from a falling SCL edge
    a_r3_write_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_en |-> $past(scl_fall_i));

    // R1: a foreign address is never acknowledged
    a_r1_foreign_addr_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_ADDR && scl_fall_i && st_q.cnt == FULL &&
         st_q.shreg[7:1] != DEV_ADDR && !start_i && !stop_i) |=> !st_q.pull);

    // R6: a NACK from the controller frees the bus
    a_r6_nack_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_TACK && scl_fall_i && st_q.nack && !start_i && !stop_i)
        |=> (!st_q.pull && st_q.state == ST_IGNORE));

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_tgt_pkg::*;
#(
    parameter int          NUM_REGS     = 8,
    parameter logic [7:0]  DEFAULT_SEED = 8'hA5,
    parameter logic [7:0]  DEFAULT_STEP = 8'h11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [BYTE_W-1:0]          wr_idx_i,
    input  logic [BYTE_W-1:0]          wr_data_i,
    input  logic [BYTE_W-1:0]          rd_idx_i,
    output logic [BYTE_W-1:0]          rd_data_o,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);

    localparam int               IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [BYTE_W:0]  LIMIT = (BYTE_W+1)'(NUM_REGS);

    logic [BYTE_W-1:0] regs_d [NUM_REGS];
    logic [BYTE_W-1:0] regs_q [NUM_REGS];
    logic              wr_hit, rd_hit;

    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        return DEFAULT_SEED + BYTE_W'(idx) * DEFAULT_STEP;
    endfunction

    assign wr_hit = ({1'b0, wr_idx_i} < LIMIT);
    assign rd_hit = ({1'b0, rd_idx_i} < LIMIT);

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (wr_en_i && wr_hit) begin
            regs_d[wr_idx_i[IDX_W-1:0]] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= reg_default(i);
            end
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    assign rd_data_o = rd_hit ? regs_q[rd_idx_i[IDX_W-1:0]] : '0;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
        assign regs_o[g*BYTE_W +: BYTE_W] = regs_q[g];
    end

    // R7: a write outside the bank changes nothing
    a_r7_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_hit) |=> (regs_o == $past(regs_o)));

    // R3: an in-range write lands in its register
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i == '0) |=> (regs_o[BYTE_W-1:0] == $past(wr_data_i)));

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
    parameter int          NUM_REGS     = 8,
    parameter logic [6:0]  DEV_ADDR     = 7'h6B,
    parameter int          SYNC_STAGES  = 2,
    parameter logic [7:0]  DEFAULT_SEED = 8'hA5,
    parameter logic [7:0]  DEFAULT_STEP = 8'h11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_pull_o,
    output logic [NUM_REGS*8-1:0] regs_o
);

    logic       sda_s, scl_rise, scl_fall, start_c, stop_c;
    logic [7:0] rd_idx, rd_data, wr_idx, wr_data;
    logic       wr_en;

    i2c_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_c),
        .stop_o     (stop_c)
    );

    i2c_tgt_fsm #(
        .DEV_ADDR (DEV_ADDR)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s_i    (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_c),
        .stop_i     (stop_c),
        .rd_data_i  (rd_data),
        .rd_idx_o   (rd_idx),
        .sda_pull_o (sda_pull_o),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .wr_data_o  (wr_data)
    );

    i2c_reg_bank #(
        .NUM_REGS     (NUM_REGS),
        .DEFAULT_SEED (DEFAULT_SEED),
        .DEFAULT_STEP (DEFAULT_STEP)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data),
        .regs_o    (regs_o)
    );

endmodule

// File: tb/tb_i2c_regbank_target.sv
`timescale 1ns/1ps
module tb_i2c_regbank_target;

    localparam int N = 8;
    localparam int H = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl_m = 1'b1;
    logic         sda_m = 1'b1;
    logic         sda_pull;
    logic [N*8-1:0] regs;
    wire          sda_line = sda_m & ~sda_pull;

    int nchk = 0, nerr = 0;
    int mon_chk = 0, mon_err = 0, r8_viol = 0;
    bit cmp_en = 1'b0, done = 1'b0;
    logic [7:0] mdl [N];
    logic [7:0] wq [$];
    logic scl_prev = 1'b1, pull_prev = 1'b0;

    always #4 clk = ~clk;

    i2c_regbank_target dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .regs_o     (regs)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R9 model compare and R8 monitor, on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_prev && scl_m && (sda_pull !== pull_prev)) r8_viol++;
            scl_prev  <= scl_m;
            pull_prev <= sda_pull;
            if (cmp_en) begin
                mon_chk++;
                for (int i = 0; i < N; i++) begin
                    if (regs[i*8 +: 8] !== mdl[i]) begin
                        mon_err++;
                        $display("FAIL R9 reg%0d actual=%h expected=%h", i, regs[i*8 +: 8], mdl[i]);
                    end
                end
            end
        end
    end

    task automatic hp;
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; hp; scl_m = 1'b1; hp; sda_m = 1'b0; hp; scl_m = 1'b0; hp;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; hp; scl_m = 1'b1; hp; sda_m = 1'b1; hp;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack_low);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hp; scl_m = 1'b1; hp; scl_m = 1'b0; hp;
        end
        sda_m = 1'b1; hp; scl_m = 1'b1; hp;
        ack_low = ~sda_line;
        scl_m = 1'b0; hp;
    endtask

    task automatic recv_byte(input logic nack_bit, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            hp; scl_m = 1'b1; hp;
            b = {b[6:0], sda_line};
            scl_m = 1'b0;
        end
        hp; sda_m = nack_bit; hp; scl_m = 1'b1; hp; scl_m = 1'b0; hp;
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] expect_rd(input int idx);
        return (idx < N) ? mdl[idx] : 8'h00;
    endfunction

    task automatic frame_done;
        repeat (6) @(negedge clk);
        cmp_en = 1'b1;
    endtask

    // write wq starting at idx; tag names the requirement
    task automatic do_write(input logic [7:0] idx, input string tag);
        logic a;
        cmp_en = 1'b0;
        bus_start;
        send_byte(8'hD6, a); chk({tag, " addr ack"}, a, 1'b1);
        send_byte(idx, a);   chk({tag, " cmd ack"}, a, 1'b1);
        for (int k = 0; k < wq.size(); k++) begin
            send_byte(wq[k], a); chk({tag, " data ack"}, a, 1'b1);
            if (int'(idx) + k < N) mdl[int'(idx) + k] = wq[k];
        end
        bus_stop;
        frame_done;
    endtask

    task automatic do_read(input logic [7:0] idx, input int n, input string tag);
        logic a;
        logic [7:0] b;
        cmp_en = 1'b0;
        bus_start;
        send_byte(8'hD6, a); chk({tag, " addr ack"}, a, 1'b1);
        send_byte(idx, a);   chk({tag, " cmd ack"}, a, 1'b1);
        bus_start;
        send_byte(8'hD7, a); chk({tag, " read addr ack"}, a, 1'b1);
        for (int k = 0; k < n; k++) begin
            recv_byte((k == n - 1), b);
            chk({tag, " read data"}, b, expect_rd(int'(idx) + k));
        end
        bus_stop;
        frame_done;
    endtask

    initial begin
        logic a;
        logic [7:0] b;
        int held;
        for (int i = 0; i < N; i++) mdl[i] = 8'(8'hA5 + 8'h11 * i);
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2 reset values
        for (int i = 0; i < N; i++) chk("R2 reset value", regs[i*8 +: 8], mdl[i]);
        chk("R2 sda released", sda_pull, 1'b0);
        cmp_en = 1'b1;

        // R1 foreign write address, then a byte that must not be acked either
        cmp_en = 1'b0;
        bus_start;
        send_byte(8'hA4, a); chk("R1 foreign addr no ack", a, 1'b0);
        send_byte(8'h00, a); chk("R1 stays off bus", a, 1'b0);
        bus_stop;
        frame_done;

        // R1 foreign read address
        cmp_en = 1'b0;
        bus_start;
        send_byte(8'hD5, a); chk("R1 foreign read addr no ack", a, 1'b0);
        bus_stop;
        frame_done;

        // R3 byte write, asymmetric value shows bit order
        wq = '{8'h5C};
        do_write(8'h02, "R3");
        chk("R3 reg2 after write", regs[2*8 +: 8], 8'h5C);
        wq = '{8'h01};
        do_write(8'h00, "R3");
        chk("R3 reg0 msb first", regs[7:0], 8'h01);

        // R4 block write stopped after three bytes
        wq = '{8'h11, 8'h22, 8'h33};
        do_write(8'h04, "R4");
        chk("R4 reg7 untouched", regs[7*8 +: 8], 8'h1C);
        chk("R4 reg6 written", regs[6*8 +: 8], 8'h33);

        // R5 byte reads
        do_read(8'h02, 1, "R5");
        wq = '{8'h80};
        do_write(8'h00, "R3");
        do_read(8'h00, 1, "R5");

        // R6 block read with ACKs, final NACK
        do_read(8'h04, 3, "R6");

        // R6 after NACK the target stays released for more clocks
        cmp_en = 1'b0;
        bus_start;
        send_byte(8'hD6, a);
        send_byte(8'h01, a);
        bus_start;
        send_byte(8'hD7, a);
        recv_byte(1'b1, b);
        chk("R6 single byte before nack", b, mdl[1]);
        held = 0;
        for (int i = 0; i < 9; i++) begin
            hp; scl_m = 1'b1; hp;
            if (sda_pull) held++;
            scl_m = 1'b0;
        end
        hp;
        chk("R6 released after nack", held, 0);
        bus_stop;
        frame_done;

        // R7 block write running past the top of the bank
        wq = '{8'h77, 8'h88, 8'h99, 8'hAA};
        do_write(8'h06, "R7");
        chk("R7 reg7 written", regs[7*8 +: 8], 8'h88);
        do_read(8'h08, 1, "R7");
        do_read(8'h07, 2, "R7");
        wq = '{8'h42};
        do_write(8'hF0, "R7");

        // R8 stop releases SDA; no SDA change while SCL high
        chk("R8 released after stop", sda_pull, 1'b0);
        chk("R8 no change while scl high", r8_viol, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr + mon_err, nchk + mon_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr + mon_err + 1, nchk + mon_chk + 1);
            $finish;
        end
    end

endmodule